// File: doc/BRIEF.md
# Framed Serial PCM Codec Port

This block is the digital serial side of one telephony codec channel. Once per frame it trades a single 8-bit PCM word with a time-division highway. The highway supplies a bit clock and an active-low frame strobe. The transmit word comes from an encoder as a parallel value. The port latches it when a window opens and shifts it out MSB first on the rising edges of the bit clock, using a data output with a separate enable that drives a three-state pad. On the falling edges it gathers the incoming serial bits. When eight have arrived it hands the complete received word to the decoder with a one-cycle valid pulse.

The same strobe has a second use. A mode input is sampled when a window opens and gives the window its role. With the mode input low the window exchanges PCM. With it high the window shifts an 8-bit control word from a dedicated control input into a control register, and the PCM output and capture stay idle. A control window normally follows the PCM window later in the same frame.

All highway inputs are brought into the system clock domain through a synchronizer, and the bit-clock edges are detected there. The bit clock must therefore be much slower than the system clock.

Top module: `pcm_serial_port`

## Requirements
- R1: A synchronous active-low reset leaves the output enable low, the control register at zero and the receive-valid pulse low.
- R2: The first rising bit-clock edge that samples the strobe low, after the strobe was last seen high (or after reset), opens a window. In a PCM window the output enable goes high and the output carries bit 7 of the transmit word.
- R3: In a PCM window each later rising edge presents the next lower bit. Bits 7 down to 0 are sent, one per rising edge, and the output holds steady between rising edges.
- R4: The transmit word is captured when the window opens. Changes on the parallel transmit input after that do not alter the bits sent in that window.
- R5: In a PCM window the serial input is sampled on falling edges, MSB first. After the eighth sample the received word appears with a receive-valid pulse exactly one system clock long. Each full PCM window gives exactly one pulse.
- R6: After eight bits, the rising edge that follows turns the output enable off even if the strobe is still low. Extra clocks with the strobe low send nothing, capture nothing and give no pulse. No new window opens until the strobe has been sampled high and then low again.
- R7: The strobe is sampled on every rising edge. A rising edge that sees it high closes any open window: the output enable goes low, and a window cut short before eight bits gives no receive pulse.
- R8: If the mode input is high at the opening edge, the window is a control window. The output enable stays low, no receive-valid pulse is produced, and the bits on the control input, sampled on falling edges MSB first, form the new control word after eight bits.
- R9: A control window closed before eight bits leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fs_n | input | 1 | Active-low frame strobe |
| mode_ctl | input | 1 | Window role at opening: 0 = PCM exchange, 1 = control load |
| tx_word | input | WORD_W | Parallel PCM word from the encoder |
| pcm_rx | input | 1 | Serial PCM input |
| ctl_rx | input | 1 | Serial control input |
| pcm_tx | output | 1 | Serial PCM output data |
| pcm_tx_en | output | 1 | Output enable for the three-state pad |
| rx_word | output | WORD_W | Last complete received PCM word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| ctl_word | output | WORD_W | Control register |

## Verification
The bench holds the strobe low for twelve bits. A port that does not stop at eight would keep driving the pad or produce a second receive pulse. The bench also ends a PCM window after four bits and a control window after four bits. A design that reports partial words would fire a stray pulse or corrupt the control register. The parallel transmit input changes on every bit, which exposes a design that shifts the live input rather than a latched copy. A control window follows PCM traffic in the same frame, so a design that lets the mode pin leak into PCM would enable the output or pulse valid during the control load.

// File: rtl/pcm_port_pkg.sv
// Package: pcm_port_pkg
// Shared types for the framed serial PCM port. Assumes nothing beyond
// IEEE 1800-2017 packages.
package pcm_port_pkg;

    // Role a strobe window takes, fixed at the edge that opens it
    typedef enum logic {
        WIN_PCM = 1'b0,
        WIN_CTL = 1'b1
    } win_kind_e;

endpackage

// File: rtl/pcm_sync.sv
// Module: pcm_sync
// Multi-bit chain of synchronizer flops, one chain per input bit. Assumes
// each bit is independent and that inputs change slowly relative to clk,
// so bits travelling together stay aligned.
module pcm_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift each flop of the chain one step toward the output
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[gi] <= RST_VAL;
                end else begin
                    stage_q[gi] <= (gi == 0) ? d : stage_q[(gi == 0) ? 0 : gi - 1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_tx_shift.sv
// Module: pcm_tx_shift
// Parallel-in serial-out register for the PCM output, MSB first. A load
// captures the word and drives its MSB. Each shift presents the next bit,
// and the shift after the last bit drops the enable. Assumes load, shift
// and abort come from bit-clock edge events.
module pcm_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         abort,
    input  logic [W-1:0] par_in,
    output logic         ser_out,
    output logic         ser_en
);

    localparam int              CW   = $clog2(W + 1);
    localparam logic [CW-1:0]   LAST = CW'(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] sent_q;

    // Load, shift or stop the outgoing word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            sent_q <= '0;
            ser_en <= 1'b0;
        end else if (abort) begin
            ser_en <= 1'b0;
            sent_q <= '0;
        end else if (load) begin
            sr_q   <= par_in;
            sent_q <= CW'(1);
            ser_en <= 1'b1;
        end else if (shift && ser_en) begin
            if (sent_q == LAST) begin
                ser_en <= 1'b0;
            end else begin
                sr_q   <= {sr_q[W-2:0], 1'b0};
                sent_q <= sent_q + CW'(1);
            end
        end
    end

    assign ser_out = sr_q[W-1];

endmodule

// File: rtl/pcm_rx_shift.sv
// Module: pcm_rx_shift
// Serial-in parallel-out register that gathers exactly W bits MSB first
// and pulses done with the last one. Further samples are ignored until the
// next clear. Assumes clear and sample never come in the same cycle.
module pcm_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         ser_in,
    output logic [W-1:0] word,
    output logic         done
);

    localparam int            CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [CW-1:0] got_q;

    // Gather bits and flag the final one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            got_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                got_q <= '0;
            end else if (sample && (got_q < FULL)) begin
                word  <= {word[W-2:0], ser_in};
                got_q <= got_q + CW'(1);
                done  <= (got_q == LAST);
            end
        end
    end

endmodule

// File: rtl/pcm_serial_port.sv
// Module: pcm_serial_port
// Serial side of one codec channel. It synchronizes the highway inputs,
// finds the bit-clock edges, opens a PCM or control window on the strobe,
// and routes the shift registers. Assumes the bit clock is at least about
// eight times slower than clk and that data is stable around each edge.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fs_n,
    input  logic              mode_ctl,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              pcm_rx,
    input  logic              ctl_rx,
    output logic              pcm_tx,
    output logic              pcm_tx_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic [WORD_W-1:0] ctl_word
);

    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;
    logic bclk_s, fs_s, mode_s, pcm_s, ctl_s;
    logic bclk_d;
    logic rise_ev, fall_ev;
    logic active_q, armed_q;
    win_kind_e win_q;
    logic win_ctl;
    logic open_ev, close_ev;
    logic [WORD_W-1:0] rx_sr;
    logic rx_done;

    assign raw_in = {bclk, fs_n, mode_ctl, pcm_rx, ctl_rx};

    pcm_sync #(
        .W      (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b01000)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (syn)
    );

    assign {bclk_s, fs_s, mode_s, pcm_s, ctl_s} = syn;

    // Delay the synchronized bit clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    assign rise_ev  = bclk_s & ~bclk_d;
    assign fall_ev  = ~bclk_s & bclk_d;
    assign open_ev  = rise_ev & ~fs_s & armed_q & ~active_q;
    assign close_ev = rise_ev & fs_s;
    assign win_ctl  = (win_q == WIN_CTL);

    // Window sequencer: open on strobe low when armed, close and re-arm on strobe high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            armed_q  <= 1'b1;
            win_q    <= WIN_PCM;
        end else if (close_ev) begin
            active_q <= 1'b0;
            armed_q  <= 1'b1;
        end else if (open_ev) begin
            active_q <= 1'b1;
            armed_q  <= 1'b0;
            win_q    <= mode_s ? WIN_CTL : WIN_PCM;
        end
    end

    pcm_tx_shift #(
        .W(WORD_W)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (open_ev & ~mode_s),
        .shift  (rise_ev & active_q & ~win_ctl & ~fs_s),
        .abort  (close_ev),
        .par_in (tx_word),
        .ser_out(pcm_tx),
        .ser_en (pcm_tx_en)
    );

    pcm_rx_shift #(
        .W(WORD_W)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (open_ev),
        .sample(fall_ev & active_q),
        .ser_in(win_ctl ? ctl_s : pcm_s),
        .word  (rx_sr),
        .done  (rx_done)
    );

    // Deliver a completed word to the decoder or the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
            ctl_word <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (rx_done) begin
                if (win_ctl) begin
                    ctl_word <= rx_sr;
                end else begin
                    rx_word  <= rx_sr;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_serial_port_chk.sv
// Module: pcm_serial_port_chk
// Property checker bound to pcm_serial_port. Watches the ports together with
// the edge events and window role the top module derives.
module pcm_serial_port_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pcm_tx,
    input logic              pcm_tx_en,
    input logic              rx_valid,
    input logic [WORD_W-1:0] ctl_word,
    input logic              rise_ev,
    input logic              win_ctl,
    input logic              rx_done
);

    // R1: the cycle after reset shows the idle state
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pcm_tx_en && (ctl_word == '0) && !rx_valid));

    // R3: output bit changes only after a rising bit-clock event
    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_tx_en && $past(pcm_tx_en) && !$past(rise_ev)) |-> $stable(pcm_tx));

    // R5: the receive pulse lasts one cycle
    assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: the output is never enabled for a control window
    assert_ctl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_tx_en) |-> !win_ctl);

    // R8: no receive pulse during a control window
    assert_ctl_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !win_ctl);

    // R9: the control register changes only on a completed control word
    assert_ctl_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_word) |-> $past(rx_done && win_ctl));

endmodule

bind pcm_serial_port pcm_serial_port_chk #(
    .WORD_W(WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcm_tx   (pcm_tx),
    .pcm_tx_en(pcm_tx_en),
    .rx_valid (rx_valid),
    .ctl_word (ctl_word),
    .rise_ev  (rise_ev),
    .win_ctl  (win_ctl),
    .rx_done  (rx_done)
);

// File: tb/tb_pcm_serial_port.sv
// Scoreboard bench for pcm_serial_port. Driver tasks shape frames on the
// bit clock and queue the expected received words. A monitor pops the queue
// on every receive pulse.
module tb_pcm_serial_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         fs_n = 1'b1;
    logic         mode_ctl = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         pcm_rx = 1'b0;
    logic         ctl_rx = 1'b0;
    logic         pcm_tx;
    logic         pcm_tx_en;
    logic [W-1:0] rx_word;
    logic         rx_valid;
    logic [W-1:0] ctl_word;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] exp_ctl = '0;
    logic prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    pcm_serial_port #(.WORD_W(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fs_n     (fs_n),
        .mode_ctl (mode_ctl),
        .tx_word  (tx_word),
        .pcm_rx   (pcm_rx),
        .ctl_rx   (ctl_rx),
        .pcm_tx   (pcm_tx),
        .pcm_tx_en(pcm_tx_en),
        .rx_word  (rx_word),
        .rx_valid (rx_valid),
        .ctl_word (ctl_word)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Idle bit periods with the strobe high
    task automatic idle_bits(int n);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1; wait_clk(8);
            bclk = 1'b0; wait_clk(8);
        end
    endtask

    // PCM window: nlow rising edges with the strobe low, then one with it high
    task automatic pcm_window(logic [W-1:0] tx, logic [W-1:0] rx, int nlow);
        @(negedge clk);
        mode_ctl = 1'b0; tx_word = tx; fs_n = 1'b0;
        wait_clk(8);
        if (nlow >= W) exp_q.push_back(rx);
        for (int i = 0; i < nlow; i++) begin
            bclk = 1'b1;
            pcm_rx = (i < W) ? rx[W-1-i] : ~pcm_rx;
            wait_clk(6);
            if (i < W) begin
                chk((i == 0) ? "R2 tx_en" : "R3 tx_en", pcm_tx_en, 1);
                chk((i == 0) ? "R2 msb" : "R4 tx bit", pcm_tx, tx[W-1-i]);
            end else begin
                chk("R6 extra clock tx_en", pcm_tx_en, 0);
            end
            tx_word = ~tx ^ W'(i);
            wait_clk(2);
            bclk = 1'b0;
            wait_clk(8);
        end
        fs_n = 1'b1;
        wait_clk(8);
        bclk = 1'b1; wait_clk(6);
        chk("R7 tx_en after strobe high", pcm_tx_en, 0);
        wait_clk(2);
        bclk = 1'b0; wait_clk(8);
    endtask

    // Control window: nlow bits shifted from the control input
    task automatic ctl_window(logic [W-1:0] cw, int nlow);
        @(negedge clk);
        mode_ctl = 1'b1; fs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nlow; i++) begin
            bclk = 1'b1;
            ctl_rx = cw[W-1-i];
            pcm_rx = i[0];
            wait_clk(6);
            chk("R8 tx_en in control window", pcm_tx_en, 0);
            wait_clk(2);
            bclk = 1'b0;
            wait_clk(8);
        end
        fs_n = 1'b1; mode_ctl = 1'b0;
        wait_clk(8);
        bclk = 1'b1; wait_clk(8);
        bclk = 1'b0; wait_clk(8);
        if (nlow >= W) begin
            exp_ctl = cw;
            chk("R8 control word", ctl_word, exp_ctl);
        end else begin
            chk("R9 partial control load", ctl_word, exp_ctl);
        end
    endtask

    // Monitor: every receive pulse must match the head of the queue (R5)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_valid) begin
                if (prev_valid) chk("R5 pulse width", 1, 0);
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected rx_valid", rx_word, 32'hFFFF_FFFF);
                end else begin
                    chk("R5 rx word", rx_word, exp_q.pop_front());
                end
            end
            prev_valid <= rx_valid;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        chk("R1 tx_en", pcm_tx_en, 0);
        chk("R1 ctl_word", ctl_word, 0);
        chk("R1 rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        idle_bits(2);

        pcm_window(8'hA5, 8'h3C, 8);
        ctl_window(8'h96, 8);
        idle_bits(1);
        pcm_window(8'h01, 8'hFE, 8);
        ctl_window(8'h5A, 4);
        pcm_window(8'hC3, 8'h81, 12);
        pcm_window(8'h7E, 8'h55, 4);
        pcm_window(8'h80, 8'h7F, 8);
        idle_bits(2);
        chk("R5 all words delivered", exp_q.size(), 0);

        @(negedge clk) rst_n = 1'b0;
        wait_clk(3);
        chk("R1 ctl_word after reset", ctl_word, 0);
        chk("R1 tx_en after reset", pcm_tx_en, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule